// File: doc/BRIEF.md
# Sticky Interrupt Controller with FIFO Threshold Events

This block collects interrupt conditions for a data-processing engine and merges them into one interrupt line. It holds a 32-bit enable register and a 32-bit request register. Ten request sources are defined. Six of them come from threshold detectors that watch the byte occupancy of three FIFOs (input, cipher output and hash output). The other four are single-cycle event pulses: frame threshold reached, cipher ready, hash ready and hash result posted.

Request bits are sticky. Hardware only ever sets them, and software clears them through a write-one-to-clear port. The interrupt line is raised when the global enable is set and at least one request bit has its own enable bit set. An acknowledge input clears the global enable and nothing else. Software must therefore clear the serviced requests and then set the global enable again. The block also drives a full level flag and an empty level flag for each FIFO, each measured against that FIFO's own thresholds.

The FIFOs are outside this block. Only their occupancy counts and their threshold values come in as inputs.

Top module: `evt_irq_hub`

## Requirements
- R1: In the enable register, bit 0 is the global enable. Bits 21 to 30 enable these sources in order: input empty, input full, cipher empty, cipher full, hash empty, hash full, frame threshold, cipher ready, hash ready, hash result. A write with `cfg_sel`=0 loads the whole register. All other bits read as zero.
- R2: The request register uses the same bit positions. Bit 0 reads as the OR of bits 21 to 30, and software cannot write it.
- R3: A one-cycle event pulse sets its request bit at the next clock edge, whatever the bit held before.
- R4: `irq_o` is high exactly when the global enable is set and some bit is set in both the request register and the enable register.
- R5: A cycle with `irq_ack` high clears enable bit 0 at the next edge. This holds even when software writes the enable register in the same cycle. Request bits and enable bits 21 to 30 keep their values.
- R6: A request bit that was not cleared raises `irq_o` again as soon as the global enable is written back to 1.
- R7: A write with `cfg_sel`=1 clears each request bit where `cfg_wdata` holds a one. Zero bits have no effect. If a source event and a clear of the same bit occur in one cycle, the bit ends up set.
- R8: `full_lvl[i]` is high while occupancy is greater than the full threshold. The full request of a FIFO is set on the edge where occupancy is equal to the threshold and the value sampled at the previous edge was below it. Reaching the threshold from above sets nothing.
- R9: `empty_lvl[i]` is high while occupancy is less than the empty threshold. The empty request is set on the edge where occupancy is equal to the threshold and the previous value was above it. Reaching the threshold from below sets nothing.
- R10: FIFO i takes its occupancy and thresholds from slice `[i*CNT_W +: CNT_W]`. The FIFO indices are 0 = input, 1 = cipher, 2 = hash. Its empty request lands in bit 21+2i and its full request in bit 22+2i.
- R11: The hash-result request (bit 30) is set on every result pulse, and `irq_ack` does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0: load enable register, 1: clear request bits |
| cfg_wdata | input | 32 | Write data |
| irq_ack | input | 1 | Interrupt acknowledge |
| fifo_occ | input | 3*CNT_W | Occupancy in bytes of each FIFO |
| fifo_full_thr | input | 3*CNT_W | Full threshold of each FIFO |
| fifo_empty_thr | input | 3*CNT_W | Empty threshold of each FIFO |
| frm_thr_evt | input | 1 | Frame-threshold event pulse |
| ciph_done_evt | input | 1 | Cipher-ready event pulse |
| hash_done_evt | input | 1 | Hash-ready event pulse |
| hash_rslt_evt | input | 1 | New hash result event pulse |
| irq_o | output | 1 | Interrupt request output |
| en_rd | output | 32 | Enable register contents |
| req_rd | output | 32 | Request register contents |
| full_lvl | output | 3 | Per-FIFO full level flag |
| empty_lvl | output | 3 | Per-FIFO empty level flag |

## Verification
The assertions assume that `rst_n` is applied for at least one edge before any check counts. They also assume that the event inputs and `irq_ack` are sampled on clock edges and that thresholds do not change while a crossing is being judged. The stimulus meets these conditions. It drives every input just after the falling edge and holds thresholds constant through each scenario. It moves occupancy one value per cycle, so that each crossing lies between two samples that the bench chooses. Before each scenario the bench clears the requests, so that the expected register image does not depend on earlier tests.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

   // number of watched FIFOs (input, cipher, hash)
   localparam int NFIFO = 3;
   // first request / enable bit used by the sources
   localparam int SRC_LSB = 21;
   // total number of request sources
   localparam int NSRC = 10;
   // global enable / global request position
   localparam int GIE_BIT = 0;

   // source index within the request field (bit = SRC_LSB + index)
   typedef enum logic [3:0] {
      SRC_IN_EMPTY   = 4'd0,
      SRC_IN_FULL    = 4'd1,
      SRC_CI_EMPTY   = 4'd2,
      SRC_CI_FULL    = 4'd3,
      SRC_HS_EMPTY   = 4'd4,
      SRC_HS_FULL    = 4'd5,
      SRC_FRM_THR    = 4'd6,
      SRC_CI_DONE    = 4'd7,
      SRC_HS_DONE    = 4'd8,
      SRC_HS_RESULT  = 4'd9
   } irq_src_e;

   localparam logic [31:0] SRC_MASK = ((32'h1 << NSRC) - 32'h1) << SRC_LSB;
   localparam logic [31:0] EN_MASK  = SRC_MASK | (32'h1 << GIE_BIT);

endpackage

// File: rtl/fifo_level_watch.sv
module fifo_level_watch #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] occ,
   input  logic [CNT_W-1:0] full_thr,
   input  logic [CNT_W-1:0] empty_thr,
   output logic             full_lvl,
   output logic             empty_lvl,
   output logic             full_hit,
   output logic             empty_hit
);

   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_width
      $error("fifo_level_watch: CNT_W must lie in 1..32");
   end

   logic [CNT_W-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= occ;
   end

   assign full_lvl  = occ > full_thr;
   assign empty_lvl = occ < empty_thr;

   // equality reached from the requested side only
   assign full_hit  = (prev_q < full_thr)  && (occ == full_thr);
   assign empty_hit = (prev_q > empty_thr) && (occ == empty_thr);

   // R8
   full_hit_not_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full_hit |-> !full_lvl);
   // R9
   empty_hit_not_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      empty_hit |-> !empty_lvl);

endmodule

// File: rtl/irq_req_bank.sv
module irq_req_bank #(
   parameter int NSRC    = 10,
   parameter int SRC_LSB = 21
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] src_set,
   input  logic            clr_en,
   input  logic [31:0]     clr_mask,
   output logic [31:0]     req
);

   if (SRC_LSB < 1 || SRC_LSB + NSRC > 32) begin : g_bad_field
      $error("irq_req_bank: source field must fit in bits 1..31");
   end

   logic [NSRC-1:0] req_q;
   logic [NSRC-1:0] clr_vec;

   assign clr_vec = clr_en ? clr_mask[SRC_LSB +: NSRC] : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) req_q <= '0;
      else        req_q <= (req_q & ~clr_vec) | src_set;
   end

   always_comb begin
      req                   = '0;
      req[SRC_LSB +: NSRC]  = req_q;
      req[0]                = |req_q;
   end

   // R3
   set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src_set != '0) |=> ((req_q & $past(src_set)) == $past(src_set)));
   // R7
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((($past(req_q) & ~req_q) & ~$past(clr_vec)) == '0));

endmodule

// File: rtl/irq_en_bank.sv
module irq_en_bank #(
   parameter logic [31:0] MASK    = 32'h7FE0_0001,
   parameter int          GIE_BIT = 0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [31:0] wr_data,
   input  logic        ack,
   output logic [31:0] en
);

   if (MASK[GIE_BIT] != 1'b1) begin : g_bad_mask
      $error("irq_en_bank: MASK must include the global enable bit");
   end

   logic [31:0] en_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q <= '0;
      end else begin
         if (wr_en) en_q <= wr_data & MASK;
         if (ack)   en_q[GIE_BIT] <= 1'b0;
      end
   end

   assign en = en_q;

   // R5
   ack_clears_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !en_q[GIE_BIT]);
   // R5
   ack_keeps_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !wr_en) |=> ((en_q & ~(32'h1 << GIE_BIT)) ==
                           ($past(en_q) & ~(32'h1 << GIE_BIT))));

endmodule

// File: rtl/evt_irq_hub.sv
module evt_irq_hub
   import evt_irq_pkg::*;
#(
   parameter int CNT_W   = 8,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_wr,
   input  logic                   cfg_sel,
   input  logic [31:0]            cfg_wdata,
   input  logic                   irq_ack,
   input  logic [NFIFO*CNT_W-1:0] fifo_occ,
   input  logic [NFIFO*CNT_W-1:0] fifo_full_thr,
   input  logic [NFIFO*CNT_W-1:0] fifo_empty_thr,
   input  logic                   frm_thr_evt,
   input  logic                   ciph_done_evt,
   input  logic                   hash_done_evt,
   input  logic                   hash_rslt_evt,
   output logic                   irq_o,
   output logic [31:0]            en_rd,
   output logic [31:0]            req_rd,
   output logic [NFIFO-1:0]       full_lvl,
   output logic [NFIFO-1:0]       empty_lvl
);

   if (2 * NFIFO + 4 != NSRC) begin : g_bad_src
      $error("evt_irq_hub: source count does not match FIFO count");
   end

   logic [NSRC-1:0]  src_set;
   logic [NFIFO-1:0] full_hit;
   logic [NFIFO-1:0] empty_hit;
   logic [31:0]      en_q;
   logic [31:0]      req_q;
   logic             irq_hit;

   for (genvar i = 0; i < NFIFO; i++) begin : g_watch
      fifo_level_watch #(.CNT_W(CNT_W)) u_watch (
         .clk       (clk),
         .rst_n     (rst_n),
         .occ       (fifo_occ[i*CNT_W +: CNT_W]),
         .full_thr  (fifo_full_thr[i*CNT_W +: CNT_W]),
         .empty_thr (fifo_empty_thr[i*CNT_W +: CNT_W]),
         .full_lvl  (full_lvl[i]),
         .empty_lvl (empty_lvl[i]),
         .full_hit  (full_hit[i]),
         .empty_hit (empty_hit[i])
      );
      assign src_set[2*i]     = empty_hit[i];
      assign src_set[2*i + 1] = full_hit[i];
   end

   assign src_set[SRC_FRM_THR]   = frm_thr_evt;
   assign src_set[SRC_CI_DONE]   = ciph_done_evt;
   assign src_set[SRC_HS_DONE]   = hash_done_evt;
   assign src_set[SRC_HS_RESULT] = hash_rslt_evt;

   irq_en_bank #(.MASK(EN_MASK), .GIE_BIT(GIE_BIT)) u_en (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_wr && !cfg_sel),
      .wr_data (cfg_wdata),
      .ack     (irq_ack),
      .en      (en_q)
   );

   irq_req_bank #(.NSRC(NSRC), .SRC_LSB(SRC_LSB)) u_req (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_set  (src_set),
      .clr_en   (cfg_wr && cfg_sel),
      .clr_mask (cfg_wdata),
      .req      (req_q)
   );

   assign irq_hit = en_q[GIE_BIT] && ((req_q & en_q & SRC_MASK) != '0);

   if (IRQ_REG) begin : g_irq_flop
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= irq_hit;
      end
      assign irq_o = irq_q;
      // R4
      irq_needs_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
         irq_o |-> $past(en_q[GIE_BIT]));
   end else begin : g_irq_comb
      assign irq_o = irq_hit;
      // R4
      irq_needs_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
         irq_o |-> (en_q[GIE_BIT] && (req_q[0] == 1'b1)));
   end

   assign en_rd  = en_q;
   assign req_rd = req_q;

endmodule

// File: tb/evt_irq_hub_bench.sv
module evt_irq_hub_bench;

   localparam int W = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_wr = 1'b0;
   logic          cfg_sel = 1'b0;
   logic [31:0]   cfg_wdata = '0;
   logic          irq_ack = 1'b0;
   logic [3*W-1:0] fifo_occ = '0;
   logic [3*W-1:0] fifo_full_thr = {3{8'd8}};
   logic [3*W-1:0] fifo_empty_thr = {3{8'd2}};
   logic          frm_thr_evt = 1'b0;
   logic          ciph_done_evt = 1'b0;
   logic          hash_done_evt = 1'b0;
   logic          hash_rslt_evt = 1'b0;
   logic          irq_o;
   logic [31:0]   en_rd;
   logic [31:0]   req_rd;
   logic [2:0]    full_lvl;
   logic [2:0]    empty_lvl;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   evt_irq_hub #(.CNT_W(W)) u_evt_irq_hub (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .irq_ack(irq_ack), .fifo_occ(fifo_occ),
      .fifo_full_thr(fifo_full_thr), .fifo_empty_thr(fifo_empty_thr),
      .frm_thr_evt(frm_thr_evt), .ciph_done_evt(ciph_done_evt),
      .hash_done_evt(hash_done_evt), .hash_rslt_evt(hash_rslt_evt),
      .irq_o(irq_o), .en_rd(en_rd), .req_rd(req_rd),
      .full_lvl(full_lvl), .empty_lvl(empty_lvl)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, got, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic sel, input logic [31:0] d);
      cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
      step();
      cfg_wr = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
   endtask

   task automatic set_occ(input int idx, input logic [7:0] v);
      fifo_occ[idx*W +: W] = v;
      step();
   endtask

   task automatic clear_all();
      wr(1'b1, 32'hFFFF_FFFF);
   endtask

   task automatic t_reset();
      chk("R1 enable after reset", en_rd, 32'h0);
      chk("R2 request after reset", req_rd, 32'h0);
      chk("R4 irq after reset", {31'b0, irq_o}, 32'h0);
      chk("R9 empty level at zero occupancy", {29'b0, empty_lvl}, 32'h7);
      chk("R8 full level at zero occupancy", {29'b0, full_lvl}, 32'h0);
   endtask

   task automatic t_enable_map();
      wr(1'b0, 32'hFFFF_FFFF);
      chk("R1 unused enable bits read zero", en_rd, 32'h7FE0_0001);
      wr(1'b0, 32'h0);
      chk("R1 enable load of zero", en_rd, 32'h0);
   endtask

   task automatic t_events();
      frm_thr_evt = 1'b1; step(); frm_thr_evt = 1'b0;
      chk("R3 frame event sets bit 27, R2 bit 0", req_rd, 32'h0800_0001);
      frm_thr_evt = 1'b1; step(); frm_thr_evt = 1'b0;
      chk("R3 repeat event keeps bit set", req_rd, 32'h0800_0001);
      hash_done_evt = 1'b1; step(); hash_done_evt = 1'b0;
      chk("R3 hash ready sets bit 29", req_rd, 32'h2800_0001);
      wr(1'b1, 32'h0000_0001);
      chk("R2 bit 0 not writable", req_rd, 32'h2800_0001);
      clear_all();
      chk("R2 bit 0 drops with all sources clear", req_rd, 32'h0);
   endtask

   task automatic t_gate();
      ciph_done_evt = 1'b1; step(); ciph_done_evt = 1'b0;
      wr(1'b0, 32'h1000_0000);
      chk("R4 no irq without global enable", {31'b0, irq_o}, 32'h0);
      wr(1'b0, 32'h1000_0001);
      chk("R4 irq with global and source enable", {31'b0, irq_o}, 32'h1);
      wr(1'b0, 32'h2000_0001);
      chk("R4 no irq for unenabled request", {31'b0, irq_o}, 32'h0);
      wr(1'b0, 32'h0);
      clear_all();
   endtask

   task automatic t_ack();
      ciph_done_evt = 1'b1; step(); ciph_done_evt = 1'b0;
      wr(1'b0, 32'h1000_0001);
      chk("R5 irq before ack", {31'b0, irq_o}, 32'h1);
      irq_ack = 1'b1; step(); irq_ack = 1'b0;
      chk("R5 ack clears only global enable", en_rd, 32'h1000_0000);
      chk("R5 ack keeps request", req_rd, 32'h1000_0001);
      chk("R5 irq low after ack", {31'b0, irq_o}, 32'h0);
      wr(1'b0, 32'h1000_0001);
      chk("R6 uncleared request raises irq again", {31'b0, irq_o}, 32'h1);
      cfg_wr = 1'b1; cfg_sel = 1'b0; cfg_wdata = 32'h1000_0001; irq_ack = 1'b1;
      step();
      cfg_wr = 1'b0; cfg_wdata = '0; irq_ack = 1'b0;
      chk("R5 ack beats same-cycle enable write", en_rd, 32'h1000_0000);
      wr(1'b0, 32'h0);
      clear_all();
   endtask

   task automatic t_w1c();
      ciph_done_evt = 1'b1; step(); ciph_done_evt = 1'b0;
      wr(1'b1, 32'h0);
      chk("R7 zero write leaves request", req_rd, 32'h1000_0001);
      wr(1'b1, 32'h1000_0000);
      chk("R7 one clears request", req_rd, 32'h0);
      hash_done_evt = 1'b1; cfg_wr = 1'b1; cfg_sel = 1'b1; cfg_wdata = 32'h2000_0000;
      step();
      hash_done_evt = 1'b0; cfg_wr = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
      chk("R7 event wins over same-cycle clear", req_rd, 32'h2000_0001);
      clear_all();
   endtask

   task automatic t_full();
      set_occ(0, 8'd7);
      chk("R8 no full request below threshold", req_rd, 32'h0);
      set_occ(0, 8'd8);
      chk("R8 full request on rise to threshold", req_rd, 32'h0040_0001);
      chk("R8 full level low at threshold", {29'b0, full_lvl}, 32'h0);
      clear_all();
      set_occ(0, 8'd9);
      chk("R8 full level above threshold", {29'b0, full_lvl}, 32'h1);
      set_occ(0, 8'd8);
      chk("R8 no full request from above", req_rd, 32'h0);
      set_occ(0, 8'd0);
      clear_all();
   endtask

   task automatic t_empty();
      set_occ(0, 8'd5);
      clear_all();
      set_occ(0, 8'd2);
      chk("R9 empty request on fall to threshold", req_rd, 32'h0020_0001);
      chk("R9 empty level low at threshold", {29'b0, empty_lvl}, 32'h6);
      set_occ(0, 8'd1);
      chk("R9 empty level below threshold", {29'b0, empty_lvl}, 32'h7);
      set_occ(0, 8'd0);
      clear_all();
      set_occ(0, 8'd2);
      chk("R9 no empty request from below", req_rd, 32'h0);
      set_occ(0, 8'd0);
      clear_all();
   endtask

   task automatic t_map();
      set_occ(1, 8'd5);
      set_occ(2, 8'd5);
      clear_all();
      fifo_occ[1*W +: W] = 8'd8;
      fifo_occ[2*W +: W] = 8'd2;
      step();
      chk("R10 cipher full bit 24, hash empty bit 25", req_rd, 32'h0300_0001);
      set_occ(1, 8'd2);
      chk("R10 cipher empty bit 23", req_rd, 32'h0380_0001);
      set_occ(2, 8'd8);
      chk("R10 hash full bit 26", req_rd, 32'h0780_0001);
      fifo_occ = '0; step();
      clear_all();
   endtask

   task automatic t_result();
      hash_rslt_evt = 1'b1; step(); hash_rslt_evt = 1'b0;
      chk("R11 result event sets bit 30", req_rd, 32'h4000_0001);
      wr(1'b0, 32'h4000_0001);
      chk("R11 result irq", {31'b0, irq_o}, 32'h1);
      irq_ack = 1'b1; step(); irq_ack = 1'b0;
      chk("R11 ack keeps result request", req_rd, 32'h4000_0001);
      hash_rslt_evt = 1'b1; step(); hash_rslt_evt = 1'b0;
      chk("R11 second result keeps bit set", req_rd, 32'h4000_0001);
      wr(1'b0, 32'h0);
      clear_all();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_enable_map();
      t_events();
      t_gate();
      t_ack();
      t_w1c();
      t_full();
      t_empty();
      t_map();
      t_result();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual hung, expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule